// File: doc/BRIEF.md
# Two-Inlet Buffered Routing Element with Backward Flow Control

This block is one node of a multistage self-routing cell fabric. It has two inlets and two outlets. Each inlet feeds its own first-in first-out queue of `DEPTH` cells. Every clock cycle is one cell slot. In each slot the block looks at the cell at the head of each queue. It reads one routing bit of that cell, at position `STAGE_BIT`, and that bit picks the outlet. The block then decides which of the head cells move forward.

Flow control runs on dedicated wires, separate from the cell paths. Each outlet receives a room signal from the queue it feeds in the next stage. Each inlet drives a room signal back to the element upstream.

A mode input chooses between two transfer disciplines:
- **Hold (backpressure):** a cell advances only when the next queue has room. Otherwise it waits at its head.
- **Discard (queue loss):** a winning head cell always advances. If it meets a full queue further on, it is lost there.

Two counters record the lost cells and the slots in which a cell was held back.

Top module: `sbe_switch`

## Requirements
- R1: After synchronous reset, both queues are empty. `out_valid` is 0, `up_ready` is 2'b11, and both counters are 0.
- R2: A head cell whose bit `STAGE_BIT` is 0 goes to outlet 0, and one whose bit is 1 goes to outlet 1. The cell appears on that outlet unchanged. Its `out_valid` bit is high in the cycle after the edge at which the cell leaves its queue.
- R3: Each queue keeps arrival order and holds at most `DEPTH` cells. It accepts at most one write and gives at most one read per slot. A cell written at an edge can leave no earlier than the next edge.
- R4: `up_ready[i]` is 1 exactly when queue i holds fewer than `DEPTH` cells at the start of the slot.
- R5: With `mode_discard`=0, an outlet carries a cell in a slot only if `ds_ready` for that outlet was 1 in that slot. A head cell that is not sent stays at the head of its queue.
- R6: With `mode_discard`=1, the winning head cell for an outlet is sent whatever the value of `ds_ready`.
- R7: When both head cells address the same outlet, a round-robin pointer picks the winner. The pointer is 0 after reset, which favours inlet 0. After such a contested cell is actually sent, the pointer moves to the other inlet.
- R8: The losing head cell of a contention stays queued and competes again in the next slot.
- R9: A write arriving while its queue is full at the start of the slot is discarded. This holds even if the queue is read in the same slot. `drop_count` grows by the number of cells discarded in that slot, which is 0, 1 or 2.
- R10: With `mode_discard`=0, `held_count` grows by one in each slot in which at least one winning head cell is blocked because `ds_ready` is low.
- R11: Head cells addressing different outlets are both sent in the same slot when their outlets allow it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one edge per cell slot |
| rst | input | 1 | Synchronous active-high reset |
| mode_discard | input | 1 | 0 = hold (backpressure), 1 = discard (queue loss) |
| in_valid | input | 2 | Cell present on inlet 0 / 1 |
| in_cell0 | input | CELL_W | Cell on inlet 0 |
| in_cell1 | input | CELL_W | Cell on inlet 1 |
| up_ready | output | 2 | Room in inlet queue, sent to the upstream stage |
| ds_ready | input | 2 | Room in the next-stage queue fed by outlet 0 / 1 |
| out_valid | output | 2 | Registered cell present on outlet 0 / 1 |
| out_cell0 | output | CELL_W | Registered cell on outlet 0 |
| out_cell1 | output | CELL_W | Registered cell on outlet 1 |
| drop_count | output | CNT_W | Cells discarded at full inlet queues |
| held_count | output | CNT_W | Slots with a winning cell held back in hold mode |

## Verification
The assertions assume the following about the inputs:
- `ds_ready` is a level that stays valid for the whole slot.
- In hold mode the upstream stage respects `up_ready`.
- `mode_discard` may change at any slot boundary.

The random stimulus keeps to these limits:
- In hold mode it offers a cell on an inlet only while the reference model shows free room in that queue.
- Only in discard mode does it drive writes into full queues, plus one directed slot that switches mode on a full queue.

Heavy contention comes from biasing the routing bit toward one outlet in part of the run.

// File: rtl/sbe_pkg.sv
package sbe_pkg;
  localparam int unsigned N_PORTS = 2;
  typedef enum logic {
    XFER_HOLD    = 1'b0,
    XFER_DISCARD = 1'b1
  } xfer_mode_e;
endpackage

// File: rtl/sbe_fifo.sv
module sbe_fifo #(
  parameter int unsigned W     = 8,
  parameter int unsigned DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         rd_en,
  output logic [W-1:0] rd_data,
  output logic         not_empty,
  output logic         has_room,
  output logic         dropped
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
  localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic          push, pop;

  assign has_room  = (cnt != FULL_CNT);
  assign not_empty = (cnt != '0);
  assign push      = wr_en && has_room;
  assign pop       = rd_en && not_empty;
  assign dropped   = wr_en && !has_room;
  assign rd_data   = mem[rp];

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push) wp <= (wp == LAST_IDX) ? '0 : wp + 1'b1;
      if (pop)  rp <= (rp == LAST_IDX) ? '0 : rp + 1'b1;
      cnt <= cnt + CW'(push) - CW'(pop);
    end
  end

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
    cnt <= FULL_CNT);
  p_no_underflow_r3: assert property (@(posedge clk) disable iff (rst)
    rd_en |-> not_empty);
  p_full_sticks_r4: assert property (@(posedge clk) disable iff (rst)
    (!has_room && !rd_en) |=> !has_room);
endmodule

// File: rtl/sbe_arb.sv
module sbe_arb
  import sbe_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               discard_mode,
  input  logic [N_PORTS-1:0] req_v,
  input  logic [N_PORTS-1:0] req_dst,
  input  logic [N_PORTS-1:0] ds_room,
  output logic [N_PORTS-1:0] pop,
  output logic [N_PORTS-1:0] go,
  output logic [N_PORTS-1:0] win,
  output logic               held
);
  logic rr;
  logic [N_PORTS-1:0] r0, r1, clash, any;

  for (genvar o = 0; o < N_PORTS; o++) begin : g_out
    assign r0[o]    = req_v[0] && (req_dst[0] == o[0]);
    assign r1[o]    = req_v[1] && (req_dst[1] == o[0]);
    assign clash[o] = r0[o] && r1[o];
    assign any[o]   = r0[o] || r1[o];
    assign win[o]   = clash[o] ? rr : r1[o];
    assign go[o]    = any[o] && (discard_mode || ds_room[o]);
  end

  assign pop[0] = go[req_dst[0]] && req_v[0] && (win[req_dst[0]] == 1'b0);
  assign pop[1] = go[req_dst[1]] && req_v[1] && (win[req_dst[1]] == 1'b1);
  assign held   = !discard_mode && |(any & ~ds_room);

  always_ff @(posedge clk) begin
    if (rst) begin
      rr <= 1'b0;
    end else begin
      for (int o = 0; o < N_PORTS; o++)
        if (clash[o] && go[o]) rr <= ~win[o];
    end
  end

  for (genvar o = 0; o < N_PORTS; o++) begin : g_chk
    p_rr_moves_r7: assert property (@(posedge clk) disable iff (rst)
      (clash[o] && go[o]) |=> (rr != $past(rr)));
  end
  p_one_pop_per_outlet_r5: assert property (@(posedge clk) disable iff (rst)
    (pop == 2'b11) |-> (req_dst[0] != req_dst[1]));
endmodule

// File: rtl/sbe_switch.sv
module sbe_switch
  import sbe_pkg::*;
#(
  parameter int unsigned CELL_W    = 8,
  parameter int unsigned DEPTH     = 4,
  parameter int unsigned STAGE_BIT = 0,
  parameter int unsigned CNT_W     = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mode_discard,
  input  logic [1:0]        in_valid,
  input  logic [CELL_W-1:0] in_cell0,
  input  logic [CELL_W-1:0] in_cell1,
  output logic [1:0]        up_ready,
  input  logic [1:0]        ds_ready,
  output logic [1:0]        out_valid,
  output logic [CELL_W-1:0] out_cell0,
  output logic [CELL_W-1:0] out_cell1,
  output logic [CNT_W-1:0]  drop_count,
  output logic [CNT_W-1:0]  held_count
);
  logic [CELL_W-1:0]  wr_cell [N_PORTS];
  logic [CELL_W-1:0]  head    [N_PORTS];
  logic [N_PORTS-1:0] hv, hdst, pop, go, win, dropped;
  logic               held;

  assign wr_cell[0] = in_cell0;
  assign wr_cell[1] = in_cell1;

  for (genvar i = 0; i < N_PORTS; i++) begin : g_q
    sbe_fifo #(.W(CELL_W), .DEPTH(DEPTH)) u_q (
      .clk(clk), .rst(rst),
      .wr_en(in_valid[i]), .wr_data(wr_cell[i]),
      .rd_en(pop[i]), .rd_data(head[i]),
      .not_empty(hv[i]), .has_room(up_ready[i]),
      .dropped(dropped[i])
    );
    assign hdst[i] = head[i][STAGE_BIT];
  end

  sbe_arb u_arb (
    .clk(clk), .rst(rst),
    .discard_mode(mode_discard == XFER_DISCARD),
    .req_v(hv), .req_dst(hdst), .ds_room(ds_ready),
    .pop(pop), .go(go), .win(win), .held(held)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= '0;
      out_cell0  <= '0;
      out_cell1  <= '0;
      drop_count <= '0;
      held_count <= '0;
    end else begin
      out_valid  <= go;
      if (go[0]) out_cell0 <= head[win[0]];
      if (go[1]) out_cell1 <= head[win[1]];
      drop_count <= drop_count + CNT_W'(dropped[0]) + CNT_W'(dropped[1]);
      if (held) held_count <= held_count + 1'b1;
    end
  end

  for (genvar o = 0; o < N_PORTS; o++) begin : g_bp
    p_bp_gate_r5: assert property (@(posedge clk) disable iff (rst)
      ($past(!mode_discard) && !$past(ds_ready[o])) |-> !out_valid[o]);
  end
  p_drop_count_r9: assert property (@(posedge clk) disable iff (rst)
    (in_valid == 2'b01 && !up_ready[0]) |=> (drop_count == $past(drop_count) + 1'b1));
  p_ready_after_reset_r1: assert property (@(posedge clk)
    $past(rst) |-> (up_ready == 2'b11 && out_valid == 2'b00));
endmodule

// File: tb/sbe_switch_tb.sv
module sbe_switch_tb;
  localparam int CLK_PERIOD = 10;
  localparam int CELL_W = 8;
  localparam int DEPTH = 4;
  localparam int SB = 0;
  localparam int CNT_W = 16;
  localparam int WATCHDOG = 100000;

  logic clk = 0, rst = 1, mode_discard = 0;
  logic [1:0] in_valid = 0, ds_ready = 0, up_ready, out_valid;
  logic [CELL_W-1:0] in_cell0 = 0, in_cell1 = 0, out_cell0, out_cell1;
  logic [CNT_W-1:0] drop_count, held_count;

  always #(CLK_PERIOD/2) clk = ~clk;

  sbe_switch #(.CELL_W(CELL_W), .DEPTH(DEPTH), .STAGE_BIT(SB), .CNT_W(CNT_W)) u_dut (
    .clk(clk), .rst(rst), .mode_discard(mode_discard), .in_valid(in_valid),
    .in_cell0(in_cell0), .in_cell1(in_cell1), .up_ready(up_ready),
    .ds_ready(ds_ready), .out_valid(out_valid), .out_cell0(out_cell0),
    .out_cell1(out_cell1), .drop_count(drop_count), .held_count(held_count));

  int n_chk = 0, n_fail = 0;
  string cur_req = "R1";

  logic [CELL_W-1:0] mq [2][DEPTH];
  int mcnt [2];
  logic mrr;
  logic [1:0] e_valid;
  logic [CELL_W-1:0] e_cell [2];
  int e_drop, e_held;

  function automatic logic dst_of(logic [CELL_W-1:0] c);
    return c[SB];
  endfunction

  function automatic int rdy_of(int i);
    return (mcnt[i] < DEPTH) ? 1 : 0;
  endfunction

  task automatic chk(input string what, input longint act, input longint exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", cur_req, what, act, exp);
    end
  endtask

  task automatic compare_all();
    chk("up_ready R4", up_ready, {1'(rdy_of(1)), 1'(rdy_of(0))});
    chk("out_valid R2", out_valid, e_valid);
    if (e_valid[0]) chk("out_cell0 R2 R3", out_cell0, e_cell[0]);
    if (e_valid[1]) chk("out_cell1 R2 R3", out_cell1, e_cell[1]);
    chk("drop_count R9", drop_count, e_drop);
    chk("held_count R10", held_count, e_held);
  endtask

  task automatic model_step();
    logic [1:0] req0, req1, gov, wn;
    logic [CELL_W-1:0] cin [2];
    int pre [2];
    logic popv [2];
    logic hld;
    cin[0] = in_cell0; cin[1] = in_cell1;
    hld = 0;
    for (int o = 0; o < 2; o++) begin
      req0[o] = (mcnt[0] > 0) && (dst_of(mq[0][0]) == o[0]);
      req1[o] = (mcnt[1] > 0) && (dst_of(mq[1][0]) == o[0]);
      wn[o] = (req0[o] && req1[o]) ? mrr : req1[o];
      gov[o] = (req0[o] || req1[o]) && (mode_discard || ds_ready[o]);
      if ((req0[o] || req1[o]) && !mode_discard && !ds_ready[o]) hld = 1;
    end
    popv[0] = 0; popv[1] = 0;
    for (int o = 0; o < 2; o++) begin
      e_valid[o] = gov[o];
      if (gov[o]) begin
        e_cell[o] = mq[wn[o]][0];
        popv[wn[o]] = 1;
        if (req0[o] && req1[o]) mrr = ~wn[o];
      end
    end
    if (hld) e_held++;
    for (int i = 0; i < 2; i++) begin
      pre[i] = mcnt[i];
      if (popv[i]) begin
        for (int k = 0; k < DEPTH - 1; k++) mq[i][k] = mq[i][k+1];
        mcnt[i]--;
      end
      if (in_valid[i]) begin
        if (pre[i] >= DEPTH) e_drop++;
        else begin mq[i][mcnt[i]] = cin[i]; mcnt[i]++; end
      end
    end
  endtask

  task automatic slot(input logic md, input logic [1:0] iv, input logic [CELL_W-1:0] c0,
                      input logic [CELL_W-1:0] c1, input logic [1:0] dr);
    mode_discard = md; in_valid = iv; in_cell0 = c0; in_cell1 = c1; ds_ready = dr;
    model_step();
    @(negedge clk);
    compare_all();
  endtask

  initial begin
    void'($urandom(32'd20240611));
    mcnt[0] = 0; mcnt[1] = 0; mrr = 0; e_valid = 0; e_drop = 0; e_held = 0;
    e_cell[0] = 0; e_cell[1] = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    cur_req = "R1";
    compare_all();

    cur_req = "R2 R11";
    slot(0, 2'b11, 8'h10, 8'h21, 2'b11);
    slot(0, 2'b11, 8'h31, 8'h40, 2'b11);
    slot(0, 2'b00, 0, 0, 2'b11);
    slot(0, 2'b00, 0, 0, 2'b11);

    cur_req = "R7 R8";
    for (int k = 0; k < 4; k++) slot(0, 2'b11, 8'(8'h50 + 2*k), 8'(8'h80 + 2*k), 2'b11);
    for (int k = 0; k < 6; k++) slot(0, 2'b00, 0, 0, 2'b11);

    cur_req = "R4 R5 R10";
    for (int k = 0; k < DEPTH; k++) slot(0, 2'b01, 8'(8'hA1 + 2*k), 0, 2'b00);
    slot(0, 2'b00, 0, 0, 2'b00);

    cur_req = "R9";
    slot(1, 2'b01, 8'hEE, 0, 2'b00);
    cur_req = "R6";
    for (int k = 0; k < DEPTH + 2; k++) slot(1, 2'b00, 0, 0, 2'b00);

    cur_req = "R3 R5 R6 R9";
    for (int n = 0; n < 3000; n++) begin
      logic md;
      logic [1:0] iv;
      logic [CELL_W-1:0] c0, c1;
      md = ((n / 200) % 2) == 1;
      iv = 2'($urandom_range(0, 3));
      c0 = 8'($urandom); c1 = 8'($urandom);
      if (n % 500 < 250) begin c0[SB] = 1'b0; c1[SB] = 1'b0; end
      if (!md) begin
        if (rdy_of(0) == 0) iv[0] = 0;
        if (rdy_of(1) == 0) iv[1] = 0;
      end
      slot(md, iv, c0, c1, 2'($urandom_range(0, 3)));
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog R1: actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule